// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits on the host side of a byte-wide parallel flash device and runs one complete program-byte or chip-erase operation for its user. On a start request it writes the two-cycle command sequence onto the flash bus. It then reads status bytes back until the device reports that it has finished, or until the device sets its timeout flag and a confirming read shows a real failure. It returns a pass, fail or timeout result.

Two completion tests are supported. In the first, the poll bit of the status byte is compared with the bit the device will hold once it is done. In the second, two back-to-back reads are compared on the toggle bit. Both tests read once more after the device timeout flag is seen, because that flag can rise in the same read in which the device finishes. After a fail or timeout, the block writes the reset command so the device returns to read mode.

Bus timing is counted in clock cycles: the write strobe low time, the write recovery time and the read access wait are all parameters. A poll-iteration limit bounds how long the block waits for the device.

Top module: `flash_op_poller`

## Requirements
- R1: A program operation (op_erase=0) writes the setup code PROG_SETUP (default 8'h10) and then writes tgt_data, with tgt_addr on the address bus for both writes.
- R2: An erase operation (op_erase=1) writes 8'h30 twice and then starts polling.
- R3: In a write cycle, CE and WE are low for exactly WE_LOW cycles while OE stays high, followed by at least WE_HIGH cycles with all strobes high. In a read cycle, CE and OE are low for exactly RD_WAIT cycles with WE high. Outside these cycles, and during reset, CE, OE and WE are high and fl_dq_oe is low.
- R4: In poll-bit mode (poll_toggle=0), each status read uses tgt_addr. The block passes when data bit 7 equals the expected bit: tgt_data[7] for a program, 1 for an erase.
- R5: In poll-bit mode, a mismatching read with bit 5 clear counts as one iteration and is followed by another read.
- R6: In poll-bit mode, a mismatching read with bit 5 set is followed by exactly one more read. That read gives a pass if bit 7 now matches the expected bit, and a fail otherwise.
- R7: In toggle mode (poll_toggle=1), status reads come in fresh pairs. Equal bit 6 in both reads of a pair gives a pass. Different bit 6 with bit 5 clear in the second read counts as one iteration, and a new pair follows.
- R8: In toggle mode, a pair whose bit 6 differs with bit 5 set in the second read is followed by one more pair. If bit 6 is equal in that pair the result is pass; if it still differs the result is fail.
- R9: After a fail or a timeout, the block writes the reset code 8'hFF: twice after a program and once after an erase. A pass writes nothing further.
- R10: When the POLL_LIMIT-th unresolved iteration occurs, the operation ends with the timeout result.
- R11: busy rises in the cycle after an accepted start and stays high until completion. done then pulses for one cycle with busy low and result valid. Result encoding: 00 none (after reset and while running), 01 pass, 10 fail, 11 timeout.
- R12: A start request while busy is high is ignored. The running operation's bus traffic and result are unchanged, and no operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| op_erase | input | 1 | 1 = chip erase, 0 = program one byte |
| poll_toggle | input | 1 | 1 = toggle-bit test, 0 = poll-bit test |
| tgt_addr | input | AW | Target byte address |
| tgt_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Outcome code (see R11) |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | 8 | Data driven to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data read from flash |

## Verification
A wrong poll phase or iteration count shows at the flash pins as one status read too many or too few. The per-transaction compare against the predicted read/write list catches this at that bus cycle, well before the done pulse. A wrong verdict shows up later: a reset-command write appears after a pass, or is missing after a fail, so the error is visible one write cycle after the decision and then again in the result code. A strobe-overlap or strobe-width error is visible in the very clock cycle it occurs, because the bench checks the pins on every cycle.

// File: rtl/fop_pkg.sv
package fop_pkg;

  localparam int POLL_BIT   = 7;
  localparam int TOGGLE_BIT = 6;
  localparam int LIMIT_BIT  = 5;

  localparam logic [7:0] ERASE_CODE = 8'h30;
  localparam logic [7:0] RESET_CODE = 8'hFF;

  localparam logic [1:0] RST_WRITES_PROG  = 2'd2;
  localparam logic [1:0] RST_WRITES_ERASE = 2'd1;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_PASS    = 2'd1,
    RES_FAIL    = 2'd2,
    RES_TIMEOUT = 2'd3
  } fop_result_e;

  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_RCHK_A = 2'd2,
    PH_RCHK_B = 2'd3
  } fop_phase_e;

  typedef enum logic [2:0] {
    VD_NEXT    = 3'd0,
    VD_PASS    = 3'd1,
    VD_FAIL    = 3'd2,
    VD_RETRY   = 3'd3,
    VD_RECHECK = 3'd4
  } fop_verdict_e;

  typedef enum logic [1:0] {
    B_IDLE = 2'd0,
    B_ACT  = 2'd1,
    B_REC  = 2'd2
  } fop_bus_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_CMD_ISS = 3'd1,
    S_CMD_WT  = 3'd2,
    S_RD_ISS  = 3'd3,
    S_RD_WT   = 3'd4,
    S_RST_ISS = 3'd5,
    S_RST_WT  = 3'd6
  } fop_seq_e;

endpackage

// File: rtl/fop_bus_cycle.sv
module fop_bus_cycle
  import fop_pkg::*;
#(
  parameter int AW      = 15,
  parameter int WE_LOW  = 3,
  parameter int WE_HIGH = 2,
  parameter int RD_WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          ack,
  output logic [7:0]    rdata,
  output logic          ce_n,
  output logic          oe_n,
  output logic          we_n,
  output logic [AW-1:0] addr,
  output logic [7:0]    dq_out,
  output logic          dq_oe,
  input  logic [7:0]    dq_in
);

  localparam int MAXC12 = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int MAXC   = (MAXC12 > RD_WAIT) ? MAXC12 : RD_WAIT;
  localparam int TCW    = (MAXC < 2) ? 1 : $clog2(MAXC + 1);
  localparam logic [TCW-1:0] LOW_LD  = TCW'(WE_LOW - 1);
  localparam logic [TCW-1:0] HIGH_LD = TCW'(WE_HIGH - 1);
  localparam logic [TCW-1:0] RD_LD   = TCW'(RD_WAIT - 1);

  fop_bus_e        state_q, state_d;
  logic [TCW-1:0]  cnt_q, cnt_d;
  logic            wr_q, wr_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [7:0]      data_q, data_d;
  logic [7:0]      rdata_q;
  logic            cap_en;
  logic            ce_n_q, oe_n_q, we_n_q, dq_oe_q;
  logic            ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wr_d    = wr_q;
    addr_d  = addr_q;
    data_d  = data_q;
    cap_en  = 1'b0;
    case (state_q)
      B_IDLE: begin
        if (req) begin
          state_d = B_ACT;
          wr_d    = req_wr;
          addr_d  = req_addr;
          data_d  = req_data;
          cnt_d   = req_wr ? LOW_LD : RD_LD;
        end
      end
      B_ACT: begin
        if (cnt_q == '0) begin
          state_d = B_REC;
          cnt_d   = wr_q ? HIGH_LD : '0;
          cap_en  = ~wr_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      B_REC: begin
        if (cnt_q == '0) begin
          state_d = B_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = B_IDLE;
    endcase
    ce_n_d  = ~(state_d == B_ACT);
    we_n_d  = ~((state_d == B_ACT) && wr_d);
    oe_n_d  = ~((state_d == B_ACT) && !wr_d);
    dq_oe_d = wr_d && (state_d != B_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= B_IDLE;
      cnt_q   <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
      we_n_q  <= we_n_d;
      dq_oe_q <= dq_oe_d;
      if (cap_en) begin
        rdata_q <= dq_in;
      end
    end
  end

  assign ack    = (state_q == B_REC) && (cnt_q == '0);
  assign rdata  = rdata_q;
  assign ce_n   = ce_n_q;
  assign oe_n   = oe_n_q;
  assign we_n   = we_n_q;
  assign addr   = addr_q;
  assign dq_out = data_q;
  assign dq_oe  = dq_oe_q;

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> oe_n_q); // R3
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_q || !oe_n_q) |-> !ce_n_q); // R3
  AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> (state_q == B_IDLE)); // R3
  AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> !dq_oe_q); // R3

endmodule

// File: rtl/fop_status_eval.sv
module fop_status_eval
  import fop_pkg::*;
(
  input  logic         mode_toggle,
  input  fop_phase_e   phase,
  input  logic         exp_poll,
  input  logic         prev_tog,
  input  logic [7:0]   rd_byte,
  output fop_verdict_e verdict
);

  logic unused_rd_low;
  assign unused_rd_low = ^rd_byte[4:0];

  logic poll_ok, tog_same, lim_set;
  assign poll_ok  = (rd_byte[POLL_BIT] == exp_poll);
  assign tog_same = (rd_byte[TOGGLE_BIT] == prev_tog);
  assign lim_set  = rd_byte[LIMIT_BIT];

  always_comb begin
    verdict = VD_FAIL;
    if (!mode_toggle) begin
      case (phase)
        PH_FIRST: begin
          if (poll_ok)      verdict = VD_PASS;
          else if (lim_set) verdict = VD_RECHECK;
          else              verdict = VD_RETRY;
        end
        PH_RCHK_A: verdict = poll_ok ? VD_PASS : VD_FAIL;
        default:   verdict = VD_FAIL;
      endcase
    end else begin
      case (phase)
        PH_FIRST:  verdict = VD_NEXT;
        PH_SECOND: begin
          if (tog_same)     verdict = VD_PASS;
          else if (lim_set) verdict = VD_RECHECK;
          else              verdict = VD_RETRY;
        end
        PH_RCHK_A: verdict = VD_NEXT;
        PH_RCHK_B: verdict = tog_same ? VD_PASS : VD_FAIL;
        default:   verdict = VD_FAIL;
      endcase
    end
  end

endmodule

// File: rtl/fop_sequencer.sv
module fop_sequencer
  import fop_pkg::*;
#(
  parameter int         AW         = 15,
  parameter int         POLL_LIMIT = 64,
  parameter logic [7:0] PROG_SETUP = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          poll_toggle,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic          bus_req,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_data,
  input  logic          bus_ack,
  input  logic          rd_tog,
  input  fop_verdict_e  verdict,
  output logic          mode_toggle,
  output fop_phase_e    phase,
  output logic          exp_poll,
  output logic          prev_tog,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);

  localparam int ICW = $clog2(POLL_LIMIT + 1);
  localparam logic [ICW-1:0] ITER_LAST = ICW'(POLL_LIMIT - 1);

  fop_seq_e        state_q, state_d;
  logic            op_q, op_d;
  logic            mode_q, mode_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [7:0]      data_q, data_d;
  fop_phase_e      phase_q, phase_d;
  logic            prev_q, prev_d;
  logic [ICW-1:0]  iter_q, iter_d;
  logic            cmd_idx_q, cmd_idx_d;
  logic [1:0]      rst_left_q, rst_left_d;
  fop_result_e     pend_q, pend_d;
  fop_result_e     result_q, result_d;
  logic            done_q, done_d;

  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    mode_d     = mode_q;
    addr_d     = addr_q;
    data_d     = data_q;
    phase_d    = phase_q;
    prev_d     = prev_q;
    iter_d     = iter_q;
    cmd_idx_d  = cmd_idx_q;
    rst_left_d = rst_left_q;
    pend_d     = pend_q;
    result_d   = result_q;
    done_d     = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          op_d      = op_erase;
          mode_d    = poll_toggle;
          addr_d    = tgt_addr;
          data_d    = tgt_data;
          phase_d   = PH_FIRST;
          iter_d    = '0;
          cmd_idx_d = 1'b0;
          result_d  = RES_NONE;
          state_d   = S_CMD_ISS;
        end
      end
      S_CMD_ISS: state_d = S_CMD_WT;
      S_CMD_WT: begin
        if (bus_ack) begin
          if (cmd_idx_q) begin
            state_d = S_RD_ISS;
          end else begin
            cmd_idx_d = 1'b1;
            state_d   = S_CMD_ISS;
          end
        end
      end
      S_RD_ISS: state_d = S_RD_WT;
      S_RD_WT: begin
        if (bus_ack) begin
          case (verdict)
            VD_NEXT: begin
              prev_d  = rd_tog;
              phase_d = (phase_q == PH_FIRST) ? PH_SECOND : PH_RCHK_B;
              state_d = S_RD_ISS;
            end
            VD_PASS: begin
              result_d = RES_PASS;
              done_d   = 1'b1;
              state_d  = S_IDLE;
            end
            VD_RETRY: begin
              if (iter_q == ITER_LAST) begin
                pend_d     = RES_TIMEOUT;
                rst_left_d = op_q ? RST_WRITES_ERASE : RST_WRITES_PROG;
                state_d    = S_RST_ISS;
              end else begin
                iter_d  = iter_q + 1'b1;
                phase_d = PH_FIRST;
                state_d = S_RD_ISS;
              end
            end
            VD_RECHECK: begin
              phase_d = PH_RCHK_A;
              state_d = S_RD_ISS;
            end
            default: begin
              pend_d     = RES_FAIL;
              rst_left_d = op_q ? RST_WRITES_ERASE : RST_WRITES_PROG;
              state_d    = S_RST_ISS;
            end
          endcase
        end
      end
      S_RST_ISS: state_d = S_RST_WT;
      S_RST_WT: begin
        if (bus_ack) begin
          if (rst_left_q == 2'd1) begin
            result_d = pend_q;
            done_d   = 1'b1;
            state_d  = S_IDLE;
          end else begin
            rst_left_d = rst_left_q - 1'b1;
            state_d    = S_RST_ISS;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      op_q       <= 1'b0;
      mode_q     <= 1'b0;
      addr_q     <= '0;
      data_q     <= '0;
      phase_q    <= PH_FIRST;
      prev_q     <= 1'b0;
      iter_q     <= '0;
      cmd_idx_q  <= 1'b0;
      rst_left_q <= '0;
      pend_q     <= RES_NONE;
      result_q   <= RES_NONE;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      op_q       <= op_d;
      mode_q     <= mode_d;
      addr_q     <= addr_d;
      data_q     <= data_d;
      phase_q    <= phase_d;
      prev_q     <= prev_d;
      iter_q     <= iter_d;
      cmd_idx_q  <= cmd_idx_d;
      rst_left_q <= rst_left_d;
      pend_q     <= pend_d;
      result_q   <= result_d;
      done_q     <= done_d;
    end
  end

  always_comb begin
    bus_req  = (state_q == S_CMD_ISS) || (state_q == S_RD_ISS) || (state_q == S_RST_ISS);
    bus_wr   = (state_q != S_RD_ISS);
    bus_addr = addr_q;
    if (state_q == S_RST_ISS) begin
      bus_data = RESET_CODE;
    end else if (op_q) begin
      bus_data = ERASE_CODE;
    end else begin
      bus_data = cmd_idx_q ? data_q : PROG_SETUP;
    end
  end

  assign mode_toggle = mode_q;
  assign phase       = phase_q;
  assign exp_poll    = op_q | data_q[POLL_BIT];
  assign prev_tog    = prev_q;
  assign busy        = (state_q != S_IDLE);
  assign done        = done_q;
  assign result      = result_q;

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R11
  AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (result_q != RES_NONE)); // R11
  AST_ITER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    iter_q < ICW'(POLL_LIMIT)); // R10
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(op_q) && $stable(addr_q) && $stable(data_q))); // R12
  AST_POLL_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> (phase_q == PH_FIRST || phase_q == PH_RCHK_A)); // R6
  AST_RESET_ONLY_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_RST_ISS) |-> (pend_q != RES_PASS && pend_q != RES_NONE)); // R9

endmodule

// File: rtl/flash_op_poller.sv
module flash_op_poller
  import fop_pkg::*;
#(
  parameter int         AW         = 15,
  parameter int         WE_LOW     = 3,
  parameter int         WE_HIGH    = 2,
  parameter int         RD_WAIT    = 2,
  parameter int         POLL_LIMIT = 64,
  parameter logic [7:0] PROG_SETUP = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic          poll_toggle,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          fl_ce_n,
  output logic          fl_oe_n,
  output logic          fl_we_n,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in
);

  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  logic          bus_req, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_data, bus_rdata;
  fop_verdict_e  verdict;
  fop_phase_e    phase;
  logic          mode_toggle, exp_poll, prev_tog;

  fop_sequencer #(
    .AW(AW), .POLL_LIMIT(POLL_LIMIT), .PROG_SETUP(PROG_SETUP)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .start(start), .op_erase(op_erase), .poll_toggle(poll_toggle),
    .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ack(bus_ack), .rd_tog(bus_rdata[TOGGLE_BIT]), .verdict(verdict),
    .mode_toggle(mode_toggle), .phase(phase), .exp_poll(exp_poll), .prev_tog(prev_tog),
    .busy(busy), .done(done), .result(result)
  );

  fop_status_eval u_eval (
    .mode_toggle(mode_toggle), .phase(phase), .exp_poll(exp_poll),
    .prev_tog(prev_tog), .rd_byte(bus_rdata), .verdict(verdict)
  );

  fop_bus_cycle #(
    .AW(AW), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_WAIT(RD_WAIT)
  ) u_bus (
    .clk(clk), .rst_n(rst_int_n),
    .req(bus_req), .req_wr(bus_wr), .req_addr(bus_addr), .req_data(bus_data),
    .ack(bus_ack), .rdata(bus_rdata),
    .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n), .addr(fl_addr),
    .dq_out(fl_dq_out), .dq_oe(fl_dq_oe), .dq_in(fl_dq_in)
  );

endmodule

// File: tb/flash_op_poller_tb.sv
`timescale 1ns/1ps
module flash_op_poller_tb;

  localparam int AW = 15;
  localparam int WE_LOW = 3;
  localparam int WE_HIGH = 2;
  localparam int RD_WAIT = 2;
  localparam int LIMIT = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_erase = 1'b0, poll_toggle = 1'b0;
  logic [AW-1:0] tgt_addr = '0;
  logic [7:0] tgt_data = '0;
  logic busy, done;
  logic [1:0] result;
  logic fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_dq_out, fl_dq_in;

  always #2 clk = ~clk;

  flash_op_poller #(
    .AW(AW), .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_WAIT(RD_WAIT),
    .POLL_LIMIT(LIMIT), .PROG_SETUP(8'h10)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .poll_toggle(poll_toggle), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
    .busy(busy), .done(done), .result(result),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // device model: status reads while busy, final byte afterwards
  bit          m_erase = 0;
  logic [7:0]  m_data = 8'h00;
  int          m_busy_n = 0;
  int          m_dq5_from = 1000;
  int          rd_idx = 0;

  function automatic logic [7:0] dev_val(int i, bit er, logic [7:0] d, int bn, int d5);
    logic [7:0] v;
    if (bn < 0 || i < bn) begin
      v = 8'h00;
      v[7] = ~(er ? 1'b1 : d[7]);
      v[6] = i[0];
      v[5] = (i >= d5);
    end else begin
      v = er ? 8'hFF : d;
    end
    return v;
  endfunction

  assign fl_dq_in = dev_val(rd_idx, m_erase, m_data, m_busy_n, m_dq5_from);

  // expected bus transactions
  bit            exp_wr[$];
  logic [AW-1:0] exp_a[$];
  logic [7:0]    exp_d[$];
  string         exp_tag[$];

  task automatic push_txn(bit w, logic [AW-1:0] a, logic [7:0] d, string tag);
    exp_wr.push_back(w);
    exp_a.push_back(a);
    exp_d.push_back(d);
    exp_tag.push_back(tag);
  endtask

  task automatic predict(bit er, bit tg, logic [AW-1:0] a, logic [7:0] d,
                         int bn, int d5, output logic [1:0] res);
    int i = 0;
    int iter = 0;
    bit fin = 0;
    bit e7 = er ? 1'b1 : d[7];
    logic [7:0] v, w;
    if (er) begin
      push_txn(1, a, 8'h30, "R2");
      push_txn(1, a, 8'h30, "R2");
    end else begin
      push_txn(1, a, 8'h10, "R1");
      push_txn(1, a, d, "R1");
    end
    res = 2'd0;
    while (!fin) begin
      if (!tg) begin
        v = dev_val(i, er, d, bn, d5); push_txn(0, a, 8'h00, "R5"); i++;
        if (v[7] == e7) begin res = 2'd1; fin = 1; end
        else if (!v[5]) begin
          iter++;
          if (iter == LIMIT) begin res = 2'd3; fin = 1; end
        end else begin
          v = dev_val(i, er, d, bn, d5); push_txn(0, a, 8'h00, "R6"); i++;
          res = (v[7] == e7) ? 2'd1 : 2'd2; fin = 1;
        end
      end else begin
        v = dev_val(i, er, d, bn, d5);
        w = dev_val(i + 1, er, d, bn, d5);
        push_txn(0, a, 8'h00, "R7"); push_txn(0, a, 8'h00, "R7"); i += 2;
        if (v[6] == w[6]) begin res = 2'd1; fin = 1; end
        else if (!w[5]) begin
          iter++;
          if (iter == LIMIT) begin res = 2'd3; fin = 1; end
        end else begin
          v = dev_val(i, er, d, bn, d5);
          w = dev_val(i + 1, er, d, bn, d5);
          push_txn(0, a, 8'h00, "R8"); push_txn(0, a, 8'h00, "R8"); i += 2;
          res = (v[6] == w[6]) ? 2'd1 : 2'd2; fin = 1;
        end
      end
    end
    if (res != 2'd1) begin
      for (int k = 0; k < (er ? 1 : 2); k++) push_txn(1, a, 8'hFF, "R9");
    end
  endtask

  // per-clock pin monitor and transaction compare
  logic prev_we = 1'b1, prev_oe = 1'b1;
  int we_low_cnt = 0, oe_low_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(fl_we_n || (fl_oe_n && !fl_ce_n), "R3", "write strobe with OE low or CE high", {fl_ce_n, fl_oe_n}, 2'b01);
      chk(fl_oe_n || (fl_we_n && !fl_ce_n), "R3", "read strobe with WE low or CE high", {fl_ce_n, fl_we_n}, 2'b01);
      if (!prev_we && fl_we_n) begin
        chk(we_low_cnt == WE_LOW, "R3", "WE low cycles", we_low_cnt, WE_LOW);
        if (exp_wr.size() == 0) begin
          chk(0, "R12", "unexpected write", fl_dq_out, 0);
        end else begin
          automatic bit w = exp_wr.pop_front();
          automatic logic [AW-1:0] a = exp_a.pop_front();
          automatic logic [7:0] d = exp_d.pop_front();
          automatic string t = exp_tag.pop_front();
          chk(w == 1'b1, t, "expected a read, saw write", 1, 0);
          chk(fl_addr == a, t, "write address", fl_addr, a);
          chk(fl_dq_out == d, t, "write data", fl_dq_out, d);
        end
      end
      if (!prev_oe && fl_oe_n) begin
        chk(oe_low_cnt == RD_WAIT, "R3", "OE low cycles", oe_low_cnt, RD_WAIT);
        rd_idx = rd_idx + 1;
        if (exp_wr.size() == 0) begin
          chk(0, "R12", "unexpected read", fl_addr, 0);
        end else begin
          automatic bit w = exp_wr.pop_front();
          automatic logic [AW-1:0] a = exp_a.pop_front();
          automatic logic [7:0] d = exp_d.pop_front();
          automatic string t = exp_tag.pop_front();
          chk(w == 1'b0 && d == 8'h00, t, "expected a write, saw read", 0, 1);
          chk(fl_addr == a, (t == "R5") ? "R4" : t, "read address", fl_addr, a);
        end
      end
      we_low_cnt = fl_we_n ? 0 : we_low_cnt + 1;
      oe_low_cnt = fl_oe_n ? 0 : oe_low_cnt + 1;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
    end
  end

  task automatic run_case(bit er, bit tg, logic [AW-1:0] a, logic [7:0] d,
                          int bn, int d5, logic [1:0] exp_res, string tag, bit poke);
    logic [1:0] pres;
    int n = 0;
    m_erase = er; m_data = d; m_busy_n = bn; m_dq5_from = d5;
    rd_idx = 0;
    predict(er, tg, a, d, bn, d5, pres);
    chk(pres == exp_res, tag, "model outcome", pres, exp_res);
    @(negedge clk);
    start = 1'b1; op_erase = er; poll_toggle = tg; tgt_addr = a; tgt_data = d;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", busy, 1);
    chk(result == 2'd0, "R11", "result while running", result, 0);
    while (n < 5000) begin
      @(negedge clk);
      if (done) break;
      chk(busy == 1'b1, "R11", "busy until done", busy, 1);
      if (poke && n == 8) begin
        start = 1'b1; op_erase = ~er; tgt_addr = ~a; tgt_data = ~d;
      end else begin
        start = 1'b0;
      end
      n++;
    end
    start = 1'b0;
    chk(n < 5000, tag, "operation completed", n, 0);
    chk(busy == 1'b0, "R11", "busy low with done", busy, 0);
    chk(result == exp_res, tag, "result code", result, exp_res);
    @(negedge clk);
    chk(done == 1'b0, "R11", "done is one cycle", done, 0);
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R12", "no operation after ignored start", busy, 0);
    chk(exp_wr.size() == 0, tag, "all expected bus cycles seen", exp_wr.size(), 0);
    exp_wr.delete(); exp_a.delete(); exp_d.delete(); exp_tag.delete();
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R11", "busy/done in reset", {busy, done}, 0);
    chk(result == 2'd0, "R11", "result in reset", result, 0);
    chk({fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe} == 4'b1110, "R3", "bus pins in reset",
        {fl_ce_n, fl_oe_n, fl_we_n, fl_dq_oe}, 4'b1110);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_case(0, 0, 15'h1234, 8'hA5, 3, 1000, 2'd1, "R4", 1);   // R1 R4 R5 R12
    run_case(0, 0, 15'h0042, 8'h3C, 3, 2,    2'd1, "R6", 0);   // settle on recheck
    run_case(0, 0, 15'h7FFF, 8'h5A, -1, 1,   2'd2, "R6", 0);   // recheck fails, R9 x2
    run_case(1, 0, 15'h0000, 8'h00, 5, 1000, 2'd1, "R2", 0);   // erase expects bit 7 = 1
    run_case(1, 1, 15'h0100, 8'h00, 4, 1000, 2'd1, "R7", 0);
    run_case(0, 1, 15'h2222, 8'h81, 3, 1,    2'd1, "R8", 0);   // toggle settles on recheck
    run_case(1, 1, 15'h0003, 8'h00, -1, 3,   2'd2, "R8", 0);   // still toggling, R9 x1
    run_case(0, 0, 15'h5555, 8'h00, -1, 1000, 2'd3, "R10", 0); // timeout, R9 x2
    run_case(1, 1, 15'h0777, 8'h00, -1, 1000, 2'd3, "R10", 1); // toggle timeout, R12

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule